// File: doc/BRIEF.md
# Barrel Shifter With Carry And Condition Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically in a single combinational pass, and it works out the condition flags for the result at the same time: carry, overflow, sign and zero. The shift amount comes either from a full register operand or from a short immediate field. In both cases only the low bits that can address a bit position are used. The result and the flags for the current operation are available in the same cycle. A small flag register stores the flags on the clock edge that follows a valid strobe.

The carry is the last bit pushed out of the operand. A shift by zero leaves the operand unchanged and clears the carry. The block also drives a per-flag update mask. This tells the surrounding status logic which condition bits a shift writes. The saturation bit is never among them. Operation decode and the register file are outside this block.

Top module: `shift_flag_unit`

## Requirements
- R1: With `op_kind` = 2'b00 (left logical), `result` is `operand` shifted left by the effective count, and zeros fill the vacated low bits.
- R2: With `op_kind` = 2'b01 (right logical), `result` is `operand` shifted right with zeros filling the vacated high bits. The code 2'b11 behaves exactly like 2'b01.
- R3: With `op_kind` = 2'b10 (right arithmetic), the vacated high bits are copied from the operand's old bit 31.
- R4: The effective count is `cnt_imm` when `use_imm` = 1 and `cnt_reg[4:0]` when `use_imm` = 0. Upper bits of `cnt_reg` and the unselected source have no effect.
- R5: The carry, `cur_flags[3]`, is the last bit shifted out. For a right shift by n it is operand bit n-1. For a left shift by n it is operand bit 32-n.
- R6: An effective count of zero makes `result` equal `operand` and forces the carry to 0.
- R7: The overflow flag, `cur_flags[2]`, is 0 for every operation.
- R8: The sign flag, `cur_flags[1]`, equals `result[31]`. The zero flag, `cur_flags[0]`, is 1 exactly when all 32 result bits are 0.
- R9: `upd_mask` is 5'b01111. Bits 0 to 3 mark zero, sign, overflow and carry as written, and bit 4 (saturation) is 0.
- R10: `flags_q` resets to 0. It takes the value of `cur_flags` on each rising edge where `op_valid` = 1, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe that loads the flag register |
| op_kind | input | 2 | Shift type: 00 left logical, 01 right logical, 10 right arithmetic, 11 right logical |
| use_imm | input | 1 | Selects the immediate count instead of the register count |
| cnt_reg | input | 32 | Register count source; only the low 5 bits are used |
| cnt_imm | input | 5 | Immediate count source |
| operand | input | 32 | Value to shift |
| result | output | 32 | Shifted value |
| cur_flags | output | 4 | Flags of the present operation {carry, overflow, sign, zero} |
| upd_mask | output | 5 | Flags written by a shift {sat, carry, overflow, sign, zero} |
| flags_q | output | 4 | Registered flags, same layout as `cur_flags` |

## Verification
The bench builds the block with its default 32-bit width, so the count is 5 bits wide. At this width the extreme counts 1 and 31 are reachable, and so is a 16-bit shift that uses only the top stage of the shifter. The left-shift carry taken from bit 32-n and the right-shift carry taken from bit n-1 can therefore both be checked at each end of the range. Register counts carry junk in bits 5 and above to show that those bits are dropped. Zero counts are applied from both count sources.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_LSL = 2'b00,
        SHF_LSR = 2'b01,
        SHF_ASR = 2'b10,
        SHF_RSV = 2'b11
    } shf_op_e;

    // bit positions inside the flag and mask vectors
    localparam int FLG_Z   = 0;
    localparam int FLG_S   = 1;
    localparam int FLG_OV  = 2;
    localparam int FLG_CY  = 3;
    localparam int FLG_SAT = 4;
    localparam int NFLAG   = 4;
    localparam int NMASK   = 5;

    typedef struct packed {
        logic cy;
        logic ov;
        logic s;
        logic z;
    } flag_t;

endpackage

// File: rtl/shf_cnt_sel.sv
module shf_cnt_sel #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic [CNT_W-1:0]  cnt_imm,
    output logic [CNT_W-1:0]  cnt_eff
);

    // only the bits that can address a position take part
    always_comb begin
        cnt_eff = use_imm ? cnt_imm : cnt_reg[CNT_W-1:0];
    end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  shf_op_e           op,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] result,
    output logic              carry
);

    // one guard bit below the data catches the last bit shifted out
    localparam int EXT_W = DATA_W + 1;

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    logic                       go_left;
    logic                       fill_bit;
    logic [DATA_W-1:0]          src;
    logic [CNT_W:0][EXT_W-1:0]  stage;
    logic [DATA_W-1:0]          right_res;

    always_comb begin
        go_left  = (op == SHF_LSL);
        fill_bit = (op == SHF_ASR) && operand[DATA_W-1];
        src      = go_left ? bit_rev(operand) : operand;
    end

    assign stage[0] = {src, 1'b0};

    generate
        for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stage[k+1] = cnt[k] ? {{SH{fill_bit}}, stage[k][EXT_W-1:SH]}
                                       : stage[k];
        end
    endgenerate

    always_comb begin
        right_res = stage[CNT_W][EXT_W-1:1];
        carry     = stage[CNT_W][0];
        result    = go_left ? bit_rev(right_res) : right_res;
    end

endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    input  logic              carry,
    output flag_t             flags,
    output logic [NMASK-1:0]  upd_mask
);

    always_comb begin
        flags.cy = carry;
        flags.ov = 1'b0;
        flags.s  = result[DATA_W-1];
        flags.z  = ~|result;
        upd_mask = '0;
        for (int i = 0; i < NFLAG; i++) begin
            upd_mask[i] = 1'b1;
        end
        upd_mask[FLG_SAT] = 1'b0;
    end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
    import shf_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic [CNT_W-1:0]  cnt_imm,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic [NFLAG-1:0]  cur_flags,
    output logic [NMASK-1:0]  upd_mask,
    output logic [NFLAG-1:0]  flags_q
);

    typedef struct packed {
        flag_t flags;
    } state_t;

    logic [CNT_W-1:0] cnt_eff;
    logic             carry_w;
    flag_t            flags_w;
    state_t           st_d;
    state_t           st_q;

    shf_cnt_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .use_imm (use_imm),
        .cnt_reg (cnt_reg),
        .cnt_imm (cnt_imm),
        .cnt_eff (cnt_eff)
    );

    shf_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_barrel (
        .op      (shf_op_e'(op_kind)),
        .operand (operand),
        .cnt     (cnt_eff),
        .result  (result),
        .carry   (carry_w)
    );

    shf_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .result   (result),
        .carry    (carry_w),
        .flags    (flags_w),
        .upd_mask (upd_mask)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            st_d.flags = flags_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_flags = flags_w;
    assign flags_q   = st_q.flags;

endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk
    import shf_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic              use_imm,
    input logic [DATA_W-1:0] cnt_reg,
    input logic [CNT_W-1:0]  cnt_imm,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] result,
    input logic [NFLAG-1:0]  cur_flags,
    input logic [NFLAG-1:0]  flags_q
);

    logic [CNT_W-1:0] eff;
    assign eff = use_imm ? cnt_imm : cnt_reg[CNT_W-1:0];

    p_left_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'b00 && eff != '0) |-> !result[0]);

    p_arith_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'b10) |-> (result[DATA_W-1] == operand[DATA_W-1]));

    p_cnt_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == '0) |-> (result == operand && !cur_flags[FLG_CY]));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_flags[FLG_OV] && !flags_q[FLG_OV]);

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_flags[FLG_Z] == (result == '0));

    p_sign_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_flags[FLG_S] == result[DATA_W-1]);

    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flags_q == $past(cur_flags)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q));

endmodule

bind shift_flag_unit shift_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .use_imm   (use_imm),
    .cnt_reg   (cnt_reg),
    .cnt_imm   (cnt_imm),
    .operand   (operand),
    .result    (result),
    .cur_flags (cur_flags),
    .flags_q   (flags_q)
);

// File: tb/shift_flag_unit_tb_top.sv
module shift_flag_unit_tb_top;

    typedef struct packed {
        logic [1:0]  op;
        logic        imm;
        logic [31:0] creg;
        logic [4:0]  cimm;
        logic [31:0] opnd;
        logic [31:0] exp_res;
        logic [3:0]  exp_flg;   // {cy, ov, s, z}
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b0, 32'd1,          5'd0,  32'h4000000F, 32'h8000001E, 4'b0010, 8'd1},  // R1
        '{2'b00, 1'b1, 32'd0,          5'd1,  32'h80000000, 32'h00000000, 4'b1001, 8'd5},  // R5
        '{2'b01, 1'b0, 32'd4,          5'd0,  32'h00000008, 32'h00000000, 4'b1001, 8'd5},  // R5
        '{2'b01, 1'b1, 32'd0,          5'd4,  32'h00000001, 32'h00000000, 4'b0001, 8'd2},  // R2
        '{2'b10, 1'b0, 32'd1,          5'd0,  32'h80000000, 32'hC0000000, 4'b0010, 8'd3},  // R3
        '{2'b10, 1'b1, 32'd0,          5'd1,  32'h40000000, 32'h20000000, 4'b0000, 8'd3},  // R3
        '{2'b01, 1'b0, 32'd0,          5'd0,  32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0010, 8'd6},  // R6
        '{2'b00, 1'b1, 32'd9,          5'd0,  32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0010, 8'd6},  // R6
        '{2'b10, 1'b0, 32'h00000024,   5'd0,  32'hF0000000, 32'hFF000000, 4'b0010, 8'd4},  // R4
        '{2'b00, 1'b0, 32'hFFFFFFE0,   5'd5,  32'h12345678, 32'h12345678, 4'b0000, 8'd4},  // R4
        '{2'b00, 1'b1, 32'd0,          5'd31, 32'h00000003, 32'h80000000, 4'b1010, 8'd5},  // R5
        '{2'b01, 1'b1, 32'd0,          5'd31, 32'h80000000, 32'h00000001, 4'b0000, 8'd2},  // R2
        '{2'b10, 1'b1, 32'd0,          5'd31, 32'h80000000, 32'hFFFFFFFF, 4'b0010, 8'd3},  // R3
        '{2'b11, 1'b0, 32'd8,          5'd0,  32'h80001234, 32'h00800012, 4'b0000, 8'd2},  // R2
        '{2'b10, 1'b1, 32'd0,          5'd16, 32'h80008000, 32'hFFFF8000, 4'b1010, 8'd5},  // R5
        '{2'b00, 1'b1, 32'd0,          5'd4,  32'h000000F1, 32'h00000F10, 4'b0000, 8'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic        use_imm;
    logic [31:0] cnt_reg;
    logic [4:0]  cnt_imm;
    logic [31:0] operand;
    logic [31:0] result;
    logic [3:0]  cur_flags;
    logic [4:0]  upd_mask;
    logic [3:0]  flags_q;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shift_flag_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .use_imm   (use_imm),
        .cnt_reg   (cnt_reg),
        .cnt_imm   (cnt_imm),
        .operand   (operand),
        .result    (result),
        .cur_flags (cur_flags),
        .upd_mask  (upd_mask),
        .flags_q   (flags_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [3:0] held;
        rst_n    = 1'b0;
        op_valid = 1'b0;
        op_kind  = 2'b00;
        use_imm  = 1'b0;
        cnt_reg  = '0;
        cnt_imm  = '0;
        operand  = '0;
        repeat (3) @(negedge clk);
        check("R10 reset value of flags_q", {28'd0, flags_q}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: combinational result/flags, then registered flags
        for (int i = 0; i < NV; i++) begin
            op_valid = 1'b1;
            op_kind  = VEC[i].op;
            use_imm  = VEC[i].imm;
            cnt_reg  = VEC[i].creg;
            cnt_imm  = VEC[i].cimm;
            operand  = VEC[i].opnd;
            #1;
            check($sformatf("R%0d vec%0d result", VEC[i].req, i), result, VEC[i].exp_res);
            check($sformatf("R%0d vec%0d flags", VEC[i].req, i), {28'd0, cur_flags},
                  {28'd0, VEC[i].exp_flg});
            check($sformatf("R9 vec%0d upd_mask", i), {27'd0, upd_mask}, 32'h0000000F);
            @(negedge clk);
            check($sformatf("R10 vec%0d flags_q captured", i), {28'd0, flags_q},
                  {28'd0, VEC[i].exp_flg});
        end

        // R7: overflow stays clear even for a large arithmetic shift of a negative value
        op_kind = 2'b10; use_imm = 1'b1; cnt_imm = 5'd30; operand = 32'hAAAAAAAA;
        #1;
        check("R7 overflow clear", {31'd0, cur_flags[2]}, 32'd0);
        check("R3 asr 30 result", result, 32'hFFFFFFFE);
        @(negedge clk);

        // R10: no strobe -> flags_q holds while cur_flags differs
        held     = flags_q;
        op_valid = 1'b0;
        op_kind  = 2'b00; use_imm = 1'b1; cnt_imm = 5'd1; operand = 32'h80000000;
        #1;
        check("R5 left carry with strobe low", {28'd0, cur_flags}, 32'h00000009);
        @(negedge clk);
        @(negedge clk);
        check("R10 flags_q held without strobe", {28'd0, flags_q}, {28'd0, held});

        // R10: reset mid-run clears the register
        op_valid = 1'b1;
        @(negedge clk);
        check("R10 capture before reset", {28'd0, flags_q}, 32'h00000009);
        op_valid = 1'b0;
        rst_n    = 1'b0;
        #1;
        check("R10 flags_q cleared by reset", {28'd0, flags_q}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule